// File: doc/BRIEF.md
# Training Mailbox Message Channel

This block is the producing end of a one-slot mailbox through which a training engine reports progress to a host processor. The engine offers a message on a valid/ready port: either a 16-bit major code or a 32-bit streaming word. The block captures one message, signals the host through a status bit, and refuses further messages until the host has finished a two-phase acknowledge.

The host sees four word-addressed registers on a simple write-strobe / combinational-read bus. It polls the status register until bit 0 drops, which means a message is waiting. It then reads the low data register, and also the high data register when the message is a streaming word. It writes 0 to the acknowledge register, waits for status bit 0 to return high, and writes 1 to re-arm the channel.

The major codes carry this meaning: 0x07 for training passed, 0xff for training failed, and 0x08 for a streaming message that follows. The first streaming word after 0x08 is a header. Its low 16 bits count the argument words that follow, and each argument goes through its own full exchange. The block moves these words without interpreting them.

Top module: `mbx_msg_channel`

## Requirements
- R1: After reset, status bit 0 reads 1, the acknowledge register reads 1, both data registers read 0 and `prod_ready` is 1.
- R2: A message offered while `prod_ready` is 1 is taken at that clock edge. From the next cycle, status bit 0 reads 0 and `prod_ready` reads 0.
- R3: For a major message (`prod_stream`=0), the low data register (word offset 0xd0032) reads `prod_word[15:0]` zero-extended, and the high data register (offset 0xd0034) reads 0, whatever the upper producer bits were.
- R4: For a streaming message (`prod_stream`=1), the low data register reads bits 15:0 and the high data register reads bits 31:16 of the 32-bit word.
- R5: A write of 0 (bus_wdata bit 0) to the acknowledge register (offset 0xd0031) while a message is pending makes status bit 0 (offset 0xd0004) read 1 and the acknowledge register read 0 from the next cycle. `prod_ready` stays 0.
- R6: A write of 1 to the acknowledge register after the write of 0 makes the acknowledge register read 1 and `prod_ready` read 1 from the next cycle.
- R7: Acknowledge writes in the wrong phase change nothing. Writing 1 while a message is pending leaves status bit 0 at 0. Writing 0 when idle, or writing 0 again after the first 0, leaves the acknowledge register and `prod_ready` unchanged.
- R8: While a message is pending, the data registers keep the captured values, even if the producer changes `prod_word` or holds `prod_valid` high.
- R9: Writes to the status or data registers have no effect. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_valid | input | 1 | Producer offers a message |
| prod_ready | output | 1 | Channel can take a message |
| prod_stream | input | 1 | 1 = streaming word, 0 = major code |
| prod_word | input | DATA_W (32) | Message payload |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W (20) | Host word offset |
| bus_wdata | input | DATA_W (32) | Host write data |
| bus_rdata | output | DATA_W (32) | Host read data, combinational on bus_addr |

## Verification
The embedded properties check every cycle that a take lowers ready and raises pending, that a pending message never changes its captured halves, that the pending state leaves only through a write of 0, and that re-arming happens only through a write of 1. The sequence rules need the bench's scenarios. These are the split of data across the two registers for each kind, the reset values, the ignoring of writes in the wrong phase and of writes to read-only registers, and a full header-plus-arguments streaming run.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        MB_IDLE = 2'd0,
        MB_PEND = 2'd1,
        MB_ACKD = 2'd2
    } mb_state_t;

    typedef struct packed {
        logic        is_stream;
        logic [31:0] word;
    } mb_msg_t;

    function automatic logic [15:0] upper_half(input mb_msg_t m);
        return m.is_stream ? m.word[31:16] : 16'h0000;
    endfunction
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              hold,
    input  mbx_pkg::mb_msg_t  msg_in,
    output logic [HALF_W-1:0] lo_q,
    output logic [HALF_W-1:0] hi_q
);
    import mbx_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (load) begin
            lo_q <= msg_in.word[HALF_W-1:0];
            hi_q <= upper_half(msg_in);
        end
    end

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!hold || ($stable(lo_q) && $stable(hi_q))));
endmodule

// File: rtl/mbx_hshake.sv
module mbx_hshake (
    input  logic                clk,
    input  logic                rst,
    input  logic                offer,
    input  logic                ack_we,
    input  logic                ack_val,
    output mbx_pkg::mb_state_t  state,
    output logic                take
);
    import mbx_pkg::*;

    mb_state_t nxt;

    assign take = offer && (state == MB_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            MB_IDLE: if (offer)              nxt = MB_PEND;
            MB_PEND: if (ack_we && !ack_val) nxt = MB_ACKD;
            MB_ACKD: if (ack_we && ack_val)  nxt = MB_IDLE;
            default:                         nxt = MB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= MB_IDLE;
        else     state <= nxt;
    end

    a_r2_take_to_pend: assert property (@(posedge clk) disable iff (rst)
        take |=> (state == MB_PEND));
    a_r5_leave_pend_on_zero: assert property (@(posedge clk) disable iff (rst)
        (state == MB_PEND) && !(ack_we && !ack_val) |=> (state == MB_PEND));
    a_r7_stay_acked: assert property (@(posedge clk) disable iff (rst)
        (state == MB_ACKD) && !(ack_we && ack_val) |=> (state == MB_ACKD));
    a_r6_rearm_on_one: assert property (@(posedge clk) disable iff (rst)
        (state == MB_ACKD) && ack_we && ack_val |=> (state == MB_IDLE));
endmodule

// File: rtl/mbx_regif.sv
module mbx_regif #(
    parameter int              ADDR_W   = 20,
    parameter int              DATA_W   = 32,
    parameter int              HALF_W   = 16,
    parameter logic [ADDR_W-1:0] OFS_STAT = 20'hd0004,
    parameter logic [ADDR_W-1:0] OFS_ACK  = 20'hd0031,
    parameter logic [ADDR_W-1:0] OFS_LO   = 20'hd0032,
    parameter logic [ADDR_W-1:0] OFS_HI   = 20'hd0034
) (
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  mbx_pkg::mb_state_t state,
    input  logic [HALF_W-1:0]  lo_q,
    input  logic [HALF_W-1:0]  hi_q,
    output logic               ack_we,
    output logic               ack_val,
    output logic [DATA_W-1:0]  bus_rdata
);
    import mbx_pkg::*;

    localparam int PAD_W = DATA_W - HALF_W;

    logic idle_bit;
    logic arm_bit;

    assign ack_we   = bus_wr && (bus_addr == OFS_ACK);
    assign ack_val  = bus_wdata[0];
    assign idle_bit = (state != MB_PEND);
    assign arm_bit  = (state != MB_ACKD);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_STAT)    bus_rdata[0] = idle_bit;
        else if (bus_addr == OFS_ACK) bus_rdata[0] = arm_bit;
        else if (bus_addr == OFS_LO)  bus_rdata = {{PAD_W{1'b0}}, lo_q};
        else if (bus_addr == OFS_HI)  bus_rdata = {{PAD_W{1'b0}}, hi_q};
    end
endmodule

// File: rtl/mbx_msg_channel.sv
module mbx_msg_channel #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_valid,
    output logic              prod_ready,
    input  logic              prod_stream,
    input  logic [DATA_W-1:0] prod_word,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    import mbx_pkg::*;

    localparam int HALF_W = DATA_W / 2;

    mb_state_t         state;
    logic              take;
    logic              ack_we;
    logic              ack_val;
    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;
    mb_msg_t           msg;

    always_comb begin
        msg           = '0;
        msg.is_stream = prod_stream;
        msg.word      = 32'(prod_word);
    end

    assign prod_ready = (state == MB_IDLE);

    mbx_hshake u_hs (
        .clk     (clk),
        .rst     (rst),
        .offer   (prod_valid),
        .ack_we  (ack_we),
        .ack_val (ack_val),
        .state   (state),
        .take    (take)
    );

    mbx_slot #(.HALF_W(HALF_W)) u_slot (
        .clk    (clk),
        .rst    (rst),
        .load   (take),
        .hold   (state == MB_PEND),
        .msg_in (msg),
        .lo_q   (lo_q),
        .hi_q   (hi_q)
    );

    mbx_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W)) u_reg (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .state     (state),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .ack_we    (ack_we),
        .ack_val   (ack_val),
        .bus_rdata (bus_rdata)
    );

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && prod_ready) |=> !prod_ready);
endmodule

// File: tb/mbx_msg_channel_tb.sv
module mbx_msg_channel_tb;
    localparam logic [19:0] A_STAT = 20'hd0004;
    localparam logic [19:0] A_ACK  = 20'hd0031;
    localparam logic [19:0] A_LO   = 20'hd0032;
    localparam logic [19:0] A_HI   = 20'hd0034;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prod_valid = 1'b0;
    logic        prod_ready;
    logic        prod_stream = 1'b0;
    logic [31:0] prod_word = '0;
    logic        bus_wr = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mbx_msg_channel u_dut (
        .clk(clk), .rst(rst),
        .prod_valid(prod_valid), .prod_ready(prod_ready),
        .prod_stream(prod_stream), .prod_word(prod_word),
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] want_lo(input logic [31:0] w);
        return {16'h0, w[15:0]};
    endfunction

    function automatic logic [31:0] want_hi(input logic s, input logic [31:0] w);
        return s ? {16'h0, w[31:16]} : 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic post(input logic s, input logic [31:0] w);
        @(negedge clk);
        chk("R2 ready before offer", {31'h0, prod_ready}, 32'h1);
        prod_valid = 1'b1; prod_stream = s; prod_word = w;
        @(negedge clk);
        prod_valid = 1'b0;
        prod_word = ~w;
        chk("R2 ready low after take", {31'h0, prod_ready}, 32'h0);
    endtask

    task automatic exchange(input logic s, input logic [31:0] w);
        logic [31:0] d;
        post(s, w);
        rd(A_STAT, d); chk("R2 status pending", d & 1, 32'h0);
        rd(A_LO, d);   chk(s ? "R4 low half" : "R3 major low", d, want_lo(w));
        rd(A_HI, d);   chk(s ? "R4 high half" : "R3 major high zero", d, want_hi(s, w));
        wr(A_ACK, 32'h0);
        rd(A_STAT, d); chk("R5 status back high", d & 1, 32'h1);
        rd(A_ACK, d);  chk("R5 ack reads 0", d, 32'h0);
        chk("R5 ready still low", {31'h0, prod_ready}, 32'h0);
        wr(A_ACK, 32'h1);
        rd(A_ACK, d);  chk("R6 ack reads 1", d, 32'h1);
        chk("R6 ready high", {31'h0, prod_ready}, 32'h1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] w;
        logic [15:0] nargs;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        rd(A_STAT, d); chk("R1 status", d, 32'h1);
        rd(A_ACK, d);  chk("R1 ack", d, 32'h1);
        rd(A_LO, d);   chk("R1 low", d, 32'h0);
        rd(A_HI, d);   chk("R1 high", d, 32'h0);
        chk("R1 ready", {31'h0, prod_ready}, 32'h1);

        // R7: write 0 while idle is ignored
        wr(A_ACK, 32'h0);
        rd(A_ACK, d); chk("R7 idle zero ignored", d, 32'h1);
        chk("R7 idle ready kept", {31'h0, prod_ready}, 32'h1);

        // R3: major code with junk upper bits
        exchange(1'b0, 32'hABCD_0007);

        // R7 and R8: wrong-phase 1, held valid, R9 writes to read-only regs
        post(1'b1, 32'h1234_5678);
        @(negedge clk);
        prod_valid = 1'b1; prod_stream = 1'b0; prod_word = 32'hFFFF_FFFF;
        wr(A_ACK, 32'h1);
        rd(A_STAT, d); chk("R7 one while pending ignored", d, 32'h0);
        wr(A_LO, 32'h0000_BEEF);
        wr(A_STAT, 32'h1);
        rd(A_LO, d); chk("R8 low held", d, 32'h5678);
        rd(A_HI, d); chk("R8 high held", d, 32'h1234);
        rd(A_STAT, d); chk("R9 status write ignored", d, 32'h0);
        rd(20'h00010, d); chk("R9 unmapped reads 0", d, 32'h0);
        @(negedge clk);
        prod_valid = 1'b0;
        wr(A_ACK, 32'h0);
        wr(A_ACK, 32'h0);
        rd(A_ACK, d); chk("R7 second zero ignored", d, 32'h0);
        chk("R7 ready stays low", {31'h0, prod_ready}, 32'h0);
        wr(A_ACK, 32'h1);
        rd(A_ACK, d); chk("R6 rearm", d, 32'h1);

        // streaming run: 0x08, header, args, then pass / fail
        for (int k = 0; k < 6; k++) begin
            exchange(1'b0, {$urandom} & 32'hFFFF_0000 | 32'h08);
            nargs = 16'($urandom % 4);
            exchange(1'b1, {16'($urandom), nargs});
            for (int a = 0; a < int'(nargs); a++) begin
                w = $urandom;
                exchange(1'b1, w);
            end
        end
        exchange(1'b0, 32'h0000_00FF);
        exchange(1'b0, 32'h0000_0007);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule